// File: doc/BRIEF.md
# PCI Memory Target with Fast Decode

This block is the target side of a 32-bit PCI agent that exposes a small word-addressed memory inside an address window. The window's position is set through the `win_base` input. The window's size is set by a parameter. The block watches each address phase. When a memory read or memory write command falls inside the window with linear burst order, the block claims the access one clock later and serves single or burst data phases with zero wait states.

Write phases store only the byte lanes that the byte enables select, and a phase with no lane enabled leaves memory untouched. Read phases drive the addressed word with its even parity one clock behind it. When a burst reaches the last word of the window, the block asserts STOP together with TRDY, so the master cannot walk past the window's end. The shared PCI lines are split into separate input, output and output-enable ports, and the tri-state buffers are left to the pad ring.

Top module: `pcit_target`

## Requirements
- R1: In an address phase, FRAME sampled low while the block is idle, the block claims the access when all of the following hold: C/BE is 0110 (memory read) or 0111 (memory write), AD[31:6] equals `win_base`, and AD[1:0] is 00. A claim drives `devsel_n` and `trdy_n` low in the very next clock.
- R2: Any other command, an address outside the window, or AD[1:0] not 00 leaves `devsel_n`, `trdy_n` and `stop_n` high and `ad_oe` low for the whole transaction, and memory stays unchanged.
- R3: Once `devsel_n` is low it stays low until a clock edge samples FRAME high, IRDY low, and TRDY or STOP low. It then goes high in the same clock that `trdy_n` and `stop_n` go high. TRDY, STOP and read data are never driven while `devsel_n` is high.
- R4: After reset, and in every address clock, `devsel_n`, `trdy_n` and `stop_n` are high and `ctl_oe`, `ad_oe` and `par_oe` are low.
- R5: A write data phase completes on an edge that samples IRDY and TRDY both low. At that edge the block stores AD[8n+7:8n] for each lane n whose C/BE[n] is low, and leaves the other lanes as they were.
- R6: A data phase with C/BE = 1111 completes normally. On a write it stores nothing. On a read it returns the stored word unchanged.
- R7: Each completed data phase advances the burst by one word (4 bytes). While IRDY is high the phase waits, and the read data on `ad_out` holds.
- R8: The data phase at the window's last word has `stop_n` low together with `trdy_n`. If FRAME is still low when that phase completes, the block raises TRDY and keeps STOP and DEVSEL low until FRAME is sampled high with IRDY low.
- R9: `par_oe` follows `ad_oe` by one clock. Whenever `par_oe` is high, `par` gives even parity over the 32 `ad_out` bits and the 4 `cbe_n` bits of the previous clock, whatever the byte enables are.
- R10: In a read, from the clock after the address phase onward, `ad_oe` is high and `ad_out` carries the stored word for the current burst address while TRDY is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_base | input | 26 | Upper address bits that select the window |
| frame_n | input | 1 | Cycle frame from the master, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases (active low) |
| ad_in | input | 32 | Address/data bus as sampled |
| ad_out | output | 32 | Read data driven onto the bus |
| ad_oe | output | 1 | Enable for the AD drivers |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| ctl_oe | output | 1 | Enable for the DEVSEL/TRDY/STOP drivers |
| par | output | 1 | Even parity for read data |
| par_oe | output | 1 | Enable for the PAR driver |

## Verification
The properties assume a well-behaved single master. The master lowers FRAME only after an idle bus. It raises FRAME only in a clock where IRDY is low. Once it asserts IRDY it holds it until the phase completes, and after a STOP it ends the burst on the next clock. All bench traffic comes from one master task that follows these rules: it inserts wait states only by delaying IRDY, it ends unclaimed accesses with a master abort after five clocks, and it changes inputs one nanosecond after the rising edge so that every sampled value is settled.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

    // Transaction tracking state of the target
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // bus idle or between transactions
        ST_SKIP = 2'd1,  // another agent's transaction in progress
        ST_XFER = 2'd2,  // claimed, moving data
        ST_STOP = 2'd3   // disconnect issued, waiting for FRAME to end
    } pcit_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
    import pcit_pkg::*;
#(
    parameter int DW       = 32,
    parameter int WIN_LOG2 = 6
) (
    input  logic [DW-1:WIN_LOG2]      addr_hi,
    input  logic [1:0]                addr_lo,
    input  logic [3:0]                cmd,
    input  logic [DW-WIN_LOG2-1:0]    base,
    output logic                      hit,
    output logic                      is_wr
);
    logic cmd_ok;

    always_comb begin
        cmd_ok = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        hit    = cmd_ok && (addr_hi == base) && (addr_lo == 2'b00);
        is_wr  = (cmd == CMD_MEM_WR);
    end

endmodule

// File: rtl/pcit_mem.sv
module pcit_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DW/8-1:0]      be,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [DW-1:0]        wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DW-1:0]        rdata
);
    localparam int LANES = DW / 8;
    localparam int WW    = $clog2(WORDS);

    logic [7:0] mem_q [WORDS][LANES];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[w][b] <= '0;
                end else if (we && be[b] && (waddr == WW'(w))) begin
                    mem_q[w][b] <= wdata[b*8 +: 8];
                end
            end

            // R5 / R6: a lane changes only when its own enable selects it
            p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && be[b] && (waddr == WW'(w))) |=> $stable(mem_q[w][b]));
        end
    end

    for (genvar b = 0; b < LANES; b++) begin : g_rd
        assign rdata[b*8 +: 8] = mem_q[raddr][b];
    end

endmodule

// File: rtl/pcit_parity.sv
module pcit_parity #(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    data,
    input  logic [DW/8-1:0]  cbe,
    input  logic             drive,
    output logic             par,
    output logic             par_oe
);
    typedef struct packed {
        logic par;
        logic oe;
    } par_regs_t;

    par_regs_t p_d, p_q;

    always_comb begin
        p_d.par = ^{data, cbe};
        p_d.oe  = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign par    = p_q.par;
    assign par_oe = p_q.oe;

endmodule

// File: rtl/pcit_target.sv
module pcit_target
    import pcit_pkg::*;
#(
    parameter int DW       = 32,
    parameter int WIN_LOG2 = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-WIN_LOG2-1:0]  win_base,
    input  logic                    frame_n,
    input  logic                    irdy_n,
    input  logic [DW/8-1:0]         cbe_n,
    input  logic [DW-1:0]           ad_in,
    output logic [DW-1:0]           ad_out,
    output logic                    ad_oe,
    output logic                    devsel_n,
    output logic                    trdy_n,
    output logic                    stop_n,
    output logic                    ctl_oe,
    output logic                    par,
    output logic                    par_oe
);
    localparam int WW    = WIN_LOG2 - 2;
    localparam int WORDS = 2 ** WW;
    localparam int LANES = DW / 8;

    typedef struct packed {
        pcit_state_e     state;
        logic            wr;
        logic [WW-1:0]   word;
        logic            devsel_n;
        logic            trdy_n;
        logic            stop_n;
    } regs_t;

    regs_t r_d, r_q;

    logic            hit, is_wr;
    logic            mem_we;
    logic            phase_done;
    logic [WW-1:0]   nxt_word;
    logic [DW-1:0]   mem_rdata;

    pcit_decode #(.DW(DW), .WIN_LOG2(WIN_LOG2)) i_decode (
        .addr_hi (ad_in[DW-1:WIN_LOG2]),
        .addr_lo (ad_in[1:0]),
        .cmd     (cbe_n[3:0]),
        .base    (win_base),
        .hit     (hit),
        .is_wr   (is_wr)
    );

    pcit_mem #(.DW(DW), .WORDS(WORDS)) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .be    (~cbe_n),
        .waddr (r_q.word),
        .wdata (ad_in),
        .raddr (r_q.word),
        .rdata (mem_rdata)
    );

    pcit_parity #(.DW(DW)) i_parity (
        .clk    (clk),
        .rst_n  (rst_n),
        .data   (ad_out),
        .cbe    (cbe_n),
        .drive  (ad_oe),
        .par    (par),
        .par_oe (par_oe)
    );

    always_comb begin
        r_d        = r_q;
        mem_we     = 1'b0;
        phase_done = !irdy_n && !r_q.trdy_n;
        nxt_word   = r_q.word + WW'(1);

        case (r_q.state)
            ST_IDLE: begin
                if (!frame_n) begin
                    if (hit) begin
                        r_d.state    = ST_XFER;
                        r_d.wr       = is_wr;
                        r_d.word     = ad_in[WIN_LOG2-1:2];
                        r_d.devsel_n = 1'b0;
                        r_d.trdy_n   = 1'b0;
                        r_d.stop_n   = !(&ad_in[WIN_LOG2-1:2]);
                    end else begin
                        r_d.state = ST_SKIP;
                    end
                end
            end
            ST_SKIP: begin
                if (frame_n && irdy_n) r_d.state = ST_IDLE;
            end
            ST_XFER: begin
                if (phase_done) begin
                    mem_we = r_q.wr;
                    if (frame_n) begin
                        r_d.state    = ST_IDLE;
                        r_d.devsel_n = 1'b1;
                        r_d.trdy_n   = 1'b1;
                        r_d.stop_n   = 1'b1;
                    end else if (!r_q.stop_n) begin
                        r_d.state  = ST_STOP;
                        r_d.trdy_n = 1'b1;
                    end else begin
                        r_d.word   = nxt_word;
                        r_d.stop_n = !(&nxt_word);
                    end
                end
            end
            ST_STOP: begin
                if (frame_n && !irdy_n) begin
                    r_d.state    = ST_IDLE;
                    r_d.devsel_n = 1'b1;
                    r_d.trdy_n   = 1'b1;
                    r_d.stop_n   = 1'b1;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.devsel_n <= 1'b1;
            r_q.trdy_n   <= 1'b1;
            r_q.stop_n   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign devsel_n = r_q.devsel_n;
    assign trdy_n   = r_q.trdy_n;
    assign stop_n   = r_q.stop_n;
    assign ctl_oe   = (r_q.state == ST_XFER) || (r_q.state == ST_STOP);
    assign ad_oe    = (r_q.state == ST_XFER) && !r_q.wr;
    assign ad_out   = mem_rdata;

    // ---------------------------------------------------------------- checks
    p_fast_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !frame_n && hit) |=> (!devsel_n && !trdy_n));

    p_no_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !frame_n && !hit) |=> (devsel_n && trdy_n && stop_n && !ad_oe));

    p_devsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && !(frame_n && !irdy_n && (!trdy_n || !stop_n))) |=> !devsel_n);

    p_release_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |-> (trdy_n && stop_n));

    p_resp_needs_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n || !stop_n || ad_oe) |-> !devsel_n);

    p_addr_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> (devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe));

    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !trdy_n && irdy_n) |=> $stable(ad_out));

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !frame_n) |=> !stop_n);

    p_par_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe == $past(ad_oe));

    p_par_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe |-> ($countones({par, $past(ad_out), $past(cbe_n)}) % 2 == 0));

endmodule

// File: tb/test_pcit_target.sv
`timescale 1ns/1ps
module test_pcit_target;

    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [3:0]  C_MRD  = 4'b0110;
    localparam logic [3:0]  C_MWR  = 4'b0111;
    localparam logic [3:0]  C_IOWR = 4'b0011;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, par, par_oe;

    int checks   = 0;
    int failures = 0;

    logic [31:0] shadow [16];
    logic [31:0] wd     [8];
    logic [3:0]  wbe    [8];
    bit          wwait  [8];
    logic [31:0] exp_q  [$];

    logic        p_oe;
    logic [31:0] p_ad;
    logic [3:0]  p_cbe;

    always #10 clk = ~clk;

    pcit_target i_pcit_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_base (BASE[31:6]),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .cbe_n    (cbe_n),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .ctl_oe   (ctl_oe),
        .par      (par),
        .par_oe   (par_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr_phases();
        for (int k = 0; k < 8; k++) begin
            wd[k] = 32'h0; wbe[k] = 4'h0; wwait[k] = 1'b0;
        end
    endtask

    // Master driver: one transaction; pushes expected read words to the scoreboard
    task automatic txn(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                       input bit claim, output int ndone);
        bit         wr;
        bit         stp;
        int         guard;
        logic [3:0] wrd;
        wr    = (cmd == C_MWR);
        ndone = 0;
        @(posedge clk); #1;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe, "R4 address clock quiet",
            {27'd0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, 32'h1C);
        @(posedge clk); #1;
        if (!claim) begin
            cbe_n = 4'h0; ad_in = 32'hFFFF_FFFF; irdy_n = 1'b0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk(devsel_n && trdy_n && stop_n && !ad_oe, "R2 unclaimed access stays quiet",
                    {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
                @(posedge clk); #1;
            end
            frame_n = 1'b1;
            @(posedge clk); #1;
            irdy_n = 1'b1; cbe_n = 4'hF;
            return;
        end
        for (int i = 0; i < n; i++) begin
            wrd   = addr[5:2] + 4'(i);
            ad_in = wr ? wd[i] : 32'h0;
            cbe_n = wbe[i];
            if (!wr) exp_q.push_back(shadow[wrd]);
            if (wwait[i]) begin
                irdy_n = 1'b1; frame_n = 1'b0;
            end else begin
                irdy_n = 1'b0; frame_n = (i == n - 1);
            end
            @(negedge clk);
            if (i == 0) begin
                chk(!devsel_n && !trdy_n, "R1 claim one clock after address",
                    {30'd0, devsel_n, trdy_n}, 32'h0);
                if (!wr) chk(ad_oe, "R10 read data driven after address", {31'd0, ad_oe}, 32'h1);
            end
            if (wwait[i]) begin
                @(posedge clk); #1;
                irdy_n = 1'b0; frame_n = (i == n - 1);
                @(negedge clk);
            end
            guard = 0;
            while (trdy_n && guard < 8) begin
                @(posedge clk); #1;
                @(negedge clk);
                guard++;
            end
            chk(!trdy_n, "R7 data phase completes", {31'd0, trdy_n}, 32'h0);
            chk(stop_n == (wrd != 4'hF), "R8 STOP only at last window word",
                {31'd0, stop_n}, {31'd0, (wrd != 4'hF)});
            stp = !stop_n;
            if (wr) begin
                for (int b = 0; b < 4; b++)
                    if (!wbe[i][b]) shadow[wrd][b*8 +: 8] = wd[i][b*8 +: 8];
            end
            @(posedge clk); #1;
            ndone++;
            if (frame_n) break;
            if (stp) begin
                frame_n = 1'b1;
                @(negedge clk);
                chk(!stop_n && !devsel_n && trdy_n, "R8 disconnect holds STOP and DEVSEL",
                    {29'd0, stop_n, devsel_n, trdy_n}, 32'h1);
                @(posedge clk); #1;
                break;
            end
        end
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !ctl_oe, "R3 release together at end",
            {28'd0, devsel_n, trdy_n, stop_n, ctl_oe}, 32'hE);
    endtask

    // Monitor: scoreboard for read data and parity
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_oe)
                chk(par_oe && (par == ^{p_ad, p_cbe}), "R9 parity one clock later",
                    {30'd0, par_oe, par}, {30'd0, 1'b1, ^{p_ad, p_cbe}});
            if (!trdy_n && !irdy_n && ad_oe) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected read data", ad_out, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(ad_out == e, "R10/R7 read data in burst order", ad_out, e);
                end
            end
        end
        p_oe  = ad_oe;
        p_ad  = ad_out;
        p_cbe = cbe_n;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired (all requirements)", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nd;
        p_oe = 1'b0; p_ad = '0; p_cbe = '0;
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        for (int k = 0; k < 16; k++) shadow[k] = 32'h0;
        clr_phases();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n && !ctl_oe && !ad_oe && !par_oe, "R4 reset state",
            {26'd0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe, par_oe}, 32'h38);
        @(posedge clk); #1; rst_n = 1'b1;

        // R1/R5: single full-word write to word 4
        clr_phases(); wd[0] = 32'hCAFE_F00D; wbe[0] = 4'b0000;
        txn(BASE + 32'h10, C_MWR, 1, 1'b1, nd);
        chk(nd == 1, "R1 single write completes", nd, 1);

        // R5/R6/R7: burst at word 2, partial lanes, zero-BE phase, wait state
        clr_phases();
        wd[0] = 32'h1111_1111; wbe[0] = 4'b0000;
        wd[1] = 32'h2222_2222; wbe[1] = 4'b1010; wwait[1] = 1'b1;
        wd[2] = 32'h3333_3333; wbe[2] = 4'b1111;
        wd[3] = 32'h4444_4444; wbe[3] = 4'b0011;
        txn(BASE + 32'h08, C_MWR, 4, 1'b1, nd);
        chk(nd == 4, "R7 write burst length", nd, 4);

        // R10/R7/R6: burst read words 0..5, wait on phase 2, zero-BE read phase
        clr_phases(); wwait[2] = 1'b1; wbe[3] = 4'b1111;
        txn(BASE, C_MRD, 6, 1'b1, nd);
        chk(nd == 6, "R7 read burst length", nd, 6);
        chk(shadow[4] == 32'hCAFE_F00D, "R6 zero-enable write stored nothing", shadow[4], 32'hCAFE_F00D);

        // R2: wrong command, outside window, non-linear order
        clr_phases();
        txn(BASE, C_IOWR, 1, 1'b0, nd);
        txn(32'h0000_2000, C_MWR, 1, 1'b0, nd);
        txn(BASE + 32'h01, C_MRD, 1, 1'b0, nd);
        clr_phases();
        txn(BASE, C_MRD, 1, 1'b1, nd);
        chk(nd == 1, "R2 memory unchanged after ignored accesses (read back)", nd, 1);

        // R8: write burst crossing the window end disconnects after word 15
        clr_phases();
        wd[0] = 32'hA0A0_0E0E; wd[1] = 32'hB1B1_0F0F; wd[2] = 32'hDEAD_0000; wd[3] = 32'hDEAD_0001;
        txn(BASE + 32'h38, C_MWR, 4, 1'b1, nd);
        chk(nd == 2, "R8 write disconnect at window end", nd, 2);
        clr_phases();
        txn(BASE + 32'h30, C_MRD, 4, 1'b1, nd);
        chk(nd == 4, "R8 read ending on last word completes", nd, 4);
        clr_phases();
        txn(BASE + 32'h3C, C_MRD, 3, 1'b1, nd);
        chk(nd == 1, "R8 read disconnect at window end", nd, 1);
        clr_phases();
        txn(BASE, C_MRD, 2, 1'b1, nd);
        chk(nd == 2, "R8 no wrap into word 0", nd, 2);

        // R5/R7: single write with wait state on last word, then read back
        clr_phases(); wd[0] = 32'h5566_7788; wbe[0] = 4'b0110; wwait[0] = 1'b1;
        txn(BASE + 32'h3C, C_MWR, 1, 1'b1, nd);
        clr_phases();
        txn(BASE + 32'h3C, C_MRD, 1, 1'b1, nd);
        chk(nd == 1, "R5 lane write read back", nd, 1);

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R10 every expected read word seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule